// File: doc/BRIEF.md
# SDRAM Command Sequencer with Armed Special Commands

This block sits between a host bus and one SDRAM block and turns each bus access into a sequence of SDRAM commands: row activate, column read or write, single-row precharge, precharge of all banks and mode register load. A small configuration interface holds a port-width field, a page-policy bit and two one-shot arming bits. Each arming bit converts one later bus access into a special command instead of a data transfer, and clears itself once that command has completed.

The page-policy bit selects how rows are handled. In the closed policy every access opens the row, issues its column commands and precharges afterwards. In the open policy the row stays open, and an access to the same row issues only column commands. An access to another row first closes the open row. Fixed command gaps (activate-to-column, after a precharge, after a mode load) are counted out before the next command. The bus acknowledge is a one-cycle pulse that follows the last gap.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), both arming bits read 0, no row is open and bus_ack is low.
- R2: Command encodings on {cs_n,ras_n,cas_n,we_n} are: activate 0011, read 0101, write 0100, precharge 0010, mode load 0000 and NOP 0111. A column command is a read for a bus read and a write for a bus write.
- R3: With the precharge-all bit armed, the next bus write issues one precharge with sd_addr[10] = 1 and no column command. Bus reads while the bit is armed run as normal transfers and leave it armed. The bit clears when the command completes.
- R4: With the mode-load bit armed, the next bus access, read or write, issues one mode load command with sd_addr equal to bus_addr[SA_W-1:0] and no column command. The bit clears when the command completes.
- R5: The port-width field decodes as 00 = 32-bit, 01 = 8-bit, 1x = 16-bit. bus_size decodes as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. The number of column commands is the transfer bytes divided by the port bytes, with a minimum of 1.
- R6: In the closed page policy (page bit 0) each transfer issues activate, its column commands and then one precharge.
- R7: In the open page policy (page bit 1) a transfer to the open row issues only column commands.
- R8: In the open page policy a transfer issues an activate only when no row is open. If a different row is open, it issues a precharge first.
- R9: Gaps are at least TRCD cycles from activate to a column command, TRP cycles after any precharge, and TMRD cycles after a mode load. bus_ack is a single-cycle pulse in the cycle after the final gap (default gaps 2, 2, 2).
- R10: A precharge-all closes the open row. A closed-policy transfer that finds a row still open precharges it before its own activate.
- R11: The activate carries bus_addr[ADDR_W-1:PAGE_W] on sd_addr. Column k of a transfer carries (bus_addr[PAGE_W-1:0] >> log2(port bytes)) + k.
- R12: With both bits armed, a bus write issues the precharge-all and leaves the mode-load bit armed for the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_arm_pchg_all | input | 1 | Value written to the precharge-all arming bit |
| cfg_arm_mode_set | input | 1 | Value written to the mode-load arming bit |
| cfg_page_mode | input | 1 | Page policy: 0 closed, 1 open |
| cfg_port_size | input | 2 | Port width code |
| pchg_all_armed | output | 1 | Current precharge-all arming bit |
| mode_set_armed | output | 1 | Current mode-load arming bit |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Transfer size code |
| bus_ack | output | 1 | Access complete pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | SA_W | SDRAM address pins |

## Verification
The main function is tried with a sequence of accesses that varies the page policy, all three port-width codes and all four transfer sizes. Same-row, new-row and policy-change accesses follow each other so that the open-row state carries between them. The counts of activates, column commands and precharges separate the closed policy from open-policy hits and misses. The latency to the acknowledge shows that each gap is counted out, and the first column address shows the shift for each port width. Directed runs then arm each special command, alone and together, with reads and with writes, to show which access each one captures and when the bit clears.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [3:0] {
      CMD_MRS  = 4'b0000,
      CMD_PRE  = 4'b0010,
      CMD_ACT  = 4'b0011,
      CMD_WR   = 4'b0100,
      CMD_RD   = 4'b0101,
      CMD_NOP  = 4'b0111
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_CLOSE,
      ST_PCALL, ST_MSET, ST_WAIT, ST_ACK
   } seq_st_e;

   typedef enum logic [1:0] {
      K_XFER, K_PCALL, K_MSET
   } req_kind_e;

   // log2 of port width in bytes: 00 -> 4B, 01 -> 1B, 1x -> 2B
   function automatic logic [2:0] port_lg2(input logic [1:0] ps);
      case (ps)
         2'b00:   return 3'd2;
         2'b01:   return 3'd0;
         default: return 3'd1;
      endcase
   endfunction

   // log2 of transfer bytes: 0 -> 1B, 1 -> 2B, 2 -> 4B, 3 -> 16B
   function automatic logic [2:0] xfer_lg2(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd0;
         2'd1:    return 3'd1;
         2'd2:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [4:0] beat_count(input logic [1:0] ps, input logic [1:0] sz);
      logic [2:0] p;
      logic [2:0] x;
      p = port_lg2(ps);
      x = xfer_lg2(sz);
      if (x > p) return 5'd1 << (x - p);
      return 5'd1;
   endfunction

endpackage

// File: rtl/sdram_seq_cfg.sv
module sdram_seq_cfg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic       wr_pchg_all,
   input  logic       wr_mode_set,
   input  logic       wr_page_mode,
   input  logic [1:0] wr_port_size,
   input  logic       done_pchg_all,
   input  logic       done_mode_set,
   output logic       pchg_all_armed,
   output logic       mode_set_armed,
   output logic       page_mode,
   output logic [1:0] port_size
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pchg_all_armed <= 1'b0;
         mode_set_armed <= 1'b0;
         page_mode      <= 1'b0;
         port_size      <= 2'b00;
      end else if (cfg_wr) begin
         pchg_all_armed <= wr_pchg_all;
         mode_set_armed <= wr_mode_set;
         page_mode      <= wr_page_mode;
         port_size      <= wr_port_size;
      end else begin
         if (done_pchg_all) pchg_all_armed <= 1'b0;
         if (done_mode_set) mode_set_armed <= 1'b0;
      end
   end

   // R3 R4: a completion pulse only arrives for a bit that was armed
   a_r3_done_armed: assert property (@(posedge clk) disable iff (!rst_n)
      done_pchg_all |-> pchg_all_armed);
   a_r4_done_armed: assert property (@(posedge clk) disable iff (!rst_n)
      done_mode_set |-> mode_set_armed);

endmodule

// File: rtl/sdram_seq_rowtrk.sv
module sdram_seq_rowtrk #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic [ROW_W-1:0] open_row,
   input  logic             close_en,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             row_valid,
   output logic             row_hit
);

   logic [ROW_W-1:0] cur_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_valid <= 1'b0;
         cur_row   <= '0;
      end else if (open_en) begin
         row_valid <= 1'b1;
         cur_row   <= open_row;
      end else if (close_en) begin
         row_valid <= 1'b0;
      end
   end

   assign row_hit = row_valid && (cur_row == cmp_row);

   // R8 R10: the sequencer never opens and closes a row in the same cycle
   a_r10_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_en && close_en));

   // R8: an activate is only issued when no row is open
   a_r8_open_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
      open_en |-> !row_valid);

endmodule

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          last
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (run && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign last = (cnt == CW'(1));

   // R9: a wait never runs on an empty count
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt != '0);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int PAGE_W = 10,
   parameter int SA_W   = 12,
   parameter int TRCD   = 2,
   parameter int TRP    = 2,
   parameter int TMRD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_arm_pchg_all,
   input  logic              cfg_arm_mode_set,
   input  logic              cfg_page_mode,
   input  logic [1:0]        cfg_port_size,
   output logic              pchg_all_armed,
   output logic              mode_set_armed,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   output logic              bus_ack,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [SA_W-1:0]   sd_addr
);

   localparam int ROW_W = ADDR_W - PAGE_W;
   localparam int MAXT  = (TRCD > TRP) ? ((TRCD > TMRD) ? TRCD : TMRD)
                                       : ((TRP > TMRD) ? TRP : TMRD);
   localparam int CW    = $clog2(MAXT + 1);
   localparam int BW    = 5;
   localparam logic [SA_W-1:0] A10_ONLY = SA_W'(1) << 10;

   initial begin : p_param_chk
      assert (TRCD >= 1 && TRP >= 1 && TMRD >= 1) else $error("gap parameters must be >= 1");
      assert (PAGE_W >= BW && PAGE_W <= 10) else $error("PAGE_W must be 5..10");
      assert (SA_W >= 11 && SA_W >= ROW_W && SA_W <= ADDR_W) else $error("SA_W out of range");
      assert (ROW_W >= 1) else $error("ADDR_W must exceed PAGE_W");
   end

   // ---------------- configuration ----------------
   logic       page_mode;
   logic [1:0] port_size;
   logic       done_pc, done_ms;

   sdram_seq_cfg u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_wr         (cfg_wr),
      .wr_pchg_all    (cfg_arm_pchg_all),
      .wr_mode_set    (cfg_arm_mode_set),
      .wr_page_mode   (cfg_page_mode),
      .wr_port_size   (cfg_port_size),
      .done_pchg_all  (done_pc),
      .done_mode_set  (done_ms),
      .pchg_all_armed (pchg_all_armed),
      .mode_set_armed (mode_set_armed),
      .page_mode      (page_mode),
      .port_size      (port_size)
   );

   // ---------------- request capture ----------------
   seq_st_e          st, ret;
   seq_st_e          nx_st, nx_ret;
   req_kind_e        kind;
   logic             rq_we, rq_pm;
   logic [ADDR_W-1:0] rq_addr;
   logic [2:0]       rq_plg;
   logic [BW-1:0]    rq_beats, beat;
   logic             accept;

   assign accept = (st == ST_IDLE) && bus_req;

   logic [ROW_W-1:0] rq_row, bus_row;
   assign rq_row  = rq_addr[ADDR_W-1:PAGE_W];
   assign bus_row = bus_addr[ADDR_W-1:PAGE_W];

   // ---------------- open-row tracker ----------------
   logic row_open, row_close, row_valid, row_hit;

   sdram_seq_rowtrk #(.ROW_W(ROW_W)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (row_open),
      .open_row  (rq_row),
      .close_en  (row_close),
      .cmp_row   (bus_row),
      .row_valid (row_valid),
      .row_hit   (row_hit)
   );

   // ---------------- gap timer ----------------
   logic          tmr_ld, tmr_last;
   logic [CW-1:0] tmr_val;

   sdram_seq_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .run      (st == ST_WAIT),
      .last     (tmr_last)
   );

   // ---------------- next-state logic ----------------
   logic          gap_use;
   logic [CW-1:0] gap;
   seq_st_e       after;
   logic          last_beat;

   assign last_beat = (beat == rq_beats - 1'b1);

   always_comb begin
      nx_st     = st;
      nx_ret    = ret;
      tmr_ld    = 1'b0;
      tmr_val   = '0;
      row_open  = 1'b0;
      row_close = 1'b0;
      done_pc   = 1'b0;
      done_ms   = 1'b0;
      gap_use   = 1'b0;
      gap       = '0;
      after     = ST_IDLE;
      case (st)
         ST_IDLE: begin
            if (bus_req) begin
               if (pchg_all_armed && bus_we)                  nx_st = ST_PCALL;
               else if (mode_set_armed)                       nx_st = ST_MSET;
               else if (row_valid && (!page_mode || !row_hit)) nx_st = ST_PRE;
               else if (row_hit && page_mode)                 nx_st = ST_COL;
               else                                           nx_st = ST_ACT;
            end
         end
         ST_PRE: begin
            row_close = 1'b1;
            gap_use = 1'b1; gap = CW'(TRP); after = ST_ACT;
         end
         ST_ACT: begin
            row_open = 1'b1;
            gap_use = 1'b1; gap = CW'(TRCD); after = ST_COL;
         end
         ST_COL: begin
            if (last_beat) nx_st = rq_pm ? ST_ACK : ST_CLOSE;
         end
         ST_CLOSE: begin
            row_close = 1'b1;
            gap_use = 1'b1; gap = CW'(TRP); after = ST_ACK;
         end
         ST_PCALL: begin
            row_close = 1'b1;
            gap_use = 1'b1; gap = CW'(TRP); after = ST_ACK;
         end
         ST_MSET: begin
            gap_use = 1'b1; gap = CW'(TMRD); after = ST_ACK;
         end
         ST_WAIT: begin
            if (tmr_last) nx_st = ret;
         end
         ST_ACK: begin
            done_pc = (kind == K_PCALL);
            done_ms = (kind == K_MSET);
            nx_st   = ST_IDLE;
         end
         default: nx_st = ST_IDLE;
      endcase
      if (gap_use) begin
         if (gap > CW'(1)) begin
            nx_st   = ST_WAIT;
            nx_ret  = after;
            tmr_ld  = 1'b1;
            tmr_val = gap - 1'b1;
         end else begin
            nx_st = after;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ret      <= ST_IDLE;
         kind     <= K_XFER;
         rq_we    <= 1'b0;
         rq_pm    <= 1'b0;
         rq_addr  <= '0;
         rq_plg   <= '0;
         rq_beats <= BW'(1);
         beat     <= '0;
      end else begin
         st  <= nx_st;
         ret <= nx_ret;
         if (accept) begin
            rq_we    <= bus_we;
            rq_pm    <= page_mode;
            rq_addr  <= bus_addr;
            rq_plg   <= port_lg2(port_size);
            rq_beats <= beat_count(port_size, bus_size);
            beat     <= '0;
            if (pchg_all_armed && bus_we) kind <= K_PCALL;
            else if (mode_set_armed)      kind <= K_MSET;
            else                          kind <= K_XFER;
         end else if (st == ST_COL) begin
            beat <= beat + 1'b1;
         end
      end
   end

   // ---------------- command and address outputs ----------------
   sd_cmd_e           cmd;
   logic [PAGE_W-1:0] col_base, col;

   assign col_base = rq_addr[PAGE_W-1:0] >> rq_plg;
   assign col      = col_base + PAGE_W'(beat);

   always_comb begin
      cmd     = CMD_NOP;
      sd_addr = '0;
      case (st)
         ST_PRE, ST_CLOSE: cmd = CMD_PRE;
         ST_PCALL: begin cmd = CMD_PRE; sd_addr = A10_ONLY; end
         ST_ACT:   begin cmd = CMD_ACT; sd_addr = SA_W'(rq_row); end
         ST_COL:   begin cmd = rq_we ? CMD_WR : CMD_RD; sd_addr = SA_W'(col); end
         ST_MSET:  begin cmd = CMD_MRS; sd_addr = rq_addr[SA_W-1:0]; end
         default:  cmd = CMD_NOP;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign bus_ack = (st == ST_ACK);

   // ---------------- command gap monitors (R9) ----------------
   localparam int GW   = $clog2(MAXT + 2);
   localparam int SATV = MAXT + 1;

   for (genvar i = 0; i < 3; i++) begin : g_gap
      localparam sd_cmd_e WATCH = (i == 0) ? CMD_ACT : ((i == 1) ? CMD_PRE : CMD_MRS);
      logic [GW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt <= GW'(SATV);
         else if (cmd == WATCH)       cnt <= GW'(1);
         else if (cnt != GW'(SATV))   cnt <= cnt + 1'b1;
      end
   end

   a_r9_trcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD || cmd == CMD_WR) |-> g_gap[0].cnt >= GW'(TRCD));
   a_r9_trp_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> g_gap[1].cnt >= GW'(TRP));
   a_r9_tmrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> g_gap[2].cnt >= GW'(TMRD));
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);

   // R3 R4: an arming bit drops without a register write only after an acknowledge
   a_r3_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pchg_all_armed) && !$past(cfg_wr)) |-> $past(bus_ack));
   a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mode_set_armed) && !$past(cfg_wr)) |-> $past(bus_ack));

   // R6: a closed-policy transfer leaves no row open at its acknowledge
   a_r6_closed_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && !rq_pm && kind == K_XFER) |-> !row_valid);

   // R7: column commands only go to an open row
   a_r7_col_open_row: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD || cmd == CMD_WR) |-> row_valid);

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

   localparam int AW  = 22;
   localparam int PW  = 10;
   localparam int SAW = 12;
   localparam int NV  = 11;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n;
   logic           cfg_wr, cfg_arm_pchg_all, cfg_arm_mode_set, cfg_page_mode;
   logic [1:0]     cfg_port_size;
   logic           pchg_all_armed, mode_set_armed;
   logic           bus_req, bus_we, bus_ack;
   logic [AW-1:0]  bus_addr;
   logic [1:0]     bus_size;
   logic           sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [SAW-1:0] sd_addr;

   sdram_cmd_seq u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_arm_pchg_all (cfg_arm_pchg_all),
      .cfg_arm_mode_set (cfg_arm_mode_set), .cfg_page_mode (cfg_page_mode),
      .cfg_port_size (cfg_port_size),
      .pchg_all_armed (pchg_all_armed), .mode_set_armed (mode_set_armed),
      .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_size (bus_size), .bus_ack (bus_ack),
      .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
      .sd_we_n (sd_we_n), .sd_addr (sd_addr)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-access observations
   int n_act, n_col, n_pre, n_pcall, n_mset, lat, col0, act_row, mset_addr, wrong_type;

   task automatic cfg(input logic pm, input logic [1:0] ps, input logic tp, input logic tm);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_page_mode = pm; cfg_port_size = ps;
      cfg_arm_pchg_all = tp; cfg_arm_mode_set = tm;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic run(input logic we, input logic [AW-1:0] a, input logic [1:0] sz);
      logic [3:0] c;
      bit done;
      n_act = 0; n_col = 0; n_pre = 0; n_pcall = 0; n_mset = 0;
      lat = 0; col0 = -1; act_row = -1; mset_addr = -1; wrong_type = 0;
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz;
      done = 1'b0;
      while (!done) begin
         @(negedge clk);
         lat++;
         c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         case (c)
            4'b0011: begin n_act++; act_row = int'(sd_addr); end
            4'b0101, 4'b0100: begin
               if (n_col == 0) col0 = int'(sd_addr);
               n_col++;
               if ((c == 4'b0100) != we) wrong_type++;
            end
            4'b0010: if (sd_addr[10]) n_pcall++; else n_pre++;
            4'b0000: begin n_mset++; mset_addr = int'(sd_addr); end
            default: ;
         endcase
         if (bus_ack) done = 1'b1;
         if (lat > 100) begin
            done = 1'b1;
            chk("R9", "acknowledge timeout", 1, 0);
         end
      end
      bus_req = 1'b0;
   endtask

   // {pm, ps, we, size, addr, exp_act, exp_col, exp_pre, exp_lat, exp_col0}
   localparam logic [51:0] VEC [NV] = '{
      {1'b0, 2'b00, 1'b0, 2'd2, 22'h000400, 2'd1, 5'd1, 2'd1, 5'd6,  10'd0},
      {1'b0, 2'b00, 1'b1, 2'd3, 22'h000810, 2'd1, 5'd4, 2'd1, 5'd9,  10'd4},
      {1'b0, 2'b01, 1'b0, 2'd1, 22'h000C02, 2'd1, 5'd2, 2'd1, 5'd7,  10'd2},
      {1'b0, 2'b10, 1'b0, 2'd3, 22'h001000, 2'd1, 5'd8, 2'd1, 5'd13, 10'd0},
      {1'b0, 2'b11, 1'b1, 2'd0, 22'h001402, 2'd1, 5'd1, 2'd1, 5'd6,  10'd1},
      {1'b1, 2'b00, 1'b0, 2'd2, 22'h002004, 2'd1, 5'd1, 2'd0, 5'd4,  10'd1},
      {1'b1, 2'b00, 1'b1, 2'd2, 22'h002008, 2'd0, 5'd1, 2'd0, 5'd2,  10'd2},
      {1'b1, 2'b00, 1'b0, 2'd3, 22'h002020, 2'd0, 5'd4, 2'd0, 5'd5,  10'd8},
      {1'b1, 2'b00, 1'b0, 2'd2, 22'h002400, 2'd1, 5'd1, 2'd1, 5'd6,  10'd0},
      {1'b0, 2'b00, 1'b0, 2'd2, 22'h002404, 2'd1, 5'd1, 2'd2, 5'd8,  10'd1},
      {1'b1, 2'b00, 1'b0, 2'd2, 22'h002404, 2'd1, 5'd1, 2'd0, 5'd4,  10'd1}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_arm_pchg_all = 1'b0; cfg_arm_mode_set = 1'b0;
      cfg_page_mode = 1'b0; cfg_port_size = 2'b00;
      bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1", "command pins", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
      chk("R1", "precharge-all armed", int'(pchg_all_armed), 0);
      chk("R1", "mode-load armed", int'(mode_set_armed), 0);
      chk("R1", "bus_ack", int'(bus_ack), 0);

      // table walk: R5 R6 R7 R8 R9 R10 R11 R2
      for (int i = 0; i < NV; i++) begin
         logic [51:0] v;
         string tag;
         v = VEC[i];
         tag = v[51] ? "R7/R8" : "R6/R10";
         cfg(v[51], v[50:49], 1'b0, 1'b0);
         run(v[48], v[45:24], v[47:46]);
         chk(tag, $sformatf("vec%0d activates", i), n_act, int'(v[23:22]));
         chk(tag, $sformatf("vec%0d precharges", i), n_pre, int'(v[16:15]));
         chk("R5", $sformatf("vec%0d column count", i), n_col, int'(v[21:17]));
         chk("R9", $sformatf("vec%0d ack latency", i), lat, int'(v[14:10]));
         chk("R11", $sformatf("vec%0d first column", i), col0, int'(v[9:0]));
         chk("R2", $sformatf("vec%0d column type", i), wrong_type, 0);
         if (n_act > 0)
            chk("R11", $sformatf("vec%0d activate row", i), act_row, int'(v[45:24] >> PW));
      end

      // R3: armed precharge-all ignores reads, captures the next write
      cfg(1'b1, 2'b00, 1'b1, 1'b0);
      run(1'b0, 22'h002404, 2'd2);
      chk("R3", "read while armed latency", lat, 2);
      chk("R3", "read while armed special", n_pcall, 0);
      @(negedge clk);
      chk("R3", "still armed after read", int'(pchg_all_armed), 1);
      run(1'b1, 22'h000000, 2'd2);
      chk("R3", "precharge-all issued", n_pcall, 1);
      chk("R3", "no column on precharge-all", n_col, 0);
      chk("R9", "precharge-all latency", lat, 3);
      @(negedge clk);
      chk("R3", "bit cleared", int'(pchg_all_armed), 0);
      run(1'b0, 22'h002404, 2'd2);
      chk("R10", "row closed by precharge-all", n_act, 1);
      chk("R10", "reopen latency", lat, 4);

      // R4: mode load on a read, then on a write
      cfg(1'b1, 2'b00, 1'b0, 1'b1);
      run(1'b0, 22'h000233, 2'd0);
      chk("R4", "mode load on read", n_mset, 1);
      chk("R4", "mode value from address", mset_addr, 'h233);
      chk("R4", "no column on mode load", n_col, 0);
      chk("R9", "mode load latency", lat, 3);
      @(negedge clk);
      chk("R4", "bit cleared", int'(mode_set_armed), 0);
      cfg(1'b1, 2'b00, 1'b0, 1'b1);
      run(1'b1, 22'h000032, 2'd2);
      chk("R4", "mode load on write", n_mset, 1);
      chk("R4", "write mode value", mset_addr, 'h032);
      chk("R4", "no write column", n_col, 0);

      // R12: both armed, a write takes the precharge-all first
      cfg(1'b1, 2'b00, 1'b1, 1'b1);
      run(1'b1, 22'h000000, 2'd2);
      chk("R12", "precharge-all first", n_pcall, 1);
      chk("R12", "no mode load yet", n_mset, 0);
      @(negedge clk);
      chk("R12", "precharge-all cleared", int'(pchg_all_armed), 0);
      chk("R12", "mode load still armed", int'(mode_set_armed), 1);
      run(1'b0, 22'h000155, 2'd2);
      chk("R12", "mode load next", n_mset, 1);
      chk("R12", "mode value", mset_addr, 'h155);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule